// File: doc/BRIEF.md
# Chained Descriptor Stream Parser

This block sits between a ring fetcher and a data mover. It takes a stream of 64-bit descriptors through a valid/ready handshake. It decodes the 4-bit type in bits 63:60 and turns each request into a short sequence of events. A request-start marker carries the 16-bit request id. One source or destination buffer entry follows for each buffer descriptor, with a 44-bit address and a byte length. A request-end marker closes the request.

Table-chaining descriptors do not take part in framing. They produce a one-cycle fetch redirect to a new 44-bit address, and they may appear anywhere, including between a header and its buffers. Null descriptors are dropped with no effect. A request may span several headers through their start and end flags. Each header declares how many buffer descriptors follow it. Any descriptor that breaks this framing raises a one-cycle error pulse and is dropped.

All outputs are registered. Each one is a single-cycle pulse, valid in the cycle after the descriptor is accepted. No output backpressure exists, and the parser accepts one descriptor per cycle.

Top module: `desc_parser`

## Requirements
- R1: A source descriptor (type 2) or destination descriptor (type 3) that the current header still allows produces `buf_valid_o` one cycle after acceptance. `buf_is_dst_o` is 0 for type 2 and 1 for type 3. The address is bits 43:0 and the byte length is bits 59:44.
- R2: A next-table descriptor (type 5) produces `redirect_valid_o` one cycle after acceptance, with `redirect_addr_o` set to bits 43:0. It does not count against the header's buffer count and does not change the framing state.
- R3: A null descriptor (type 0) produces no output pulse and does not change the framing state.
- R4: A header descriptor (type 1) that arrives when no buffers are pending loads the buffer count from bits 40:36 and the request id from bits 15:0. If bit 56 (start) is set, the header pulses `req_start_o` with that id.
- R5: A buffer descriptor that arrives when no buffers are pending pulses `err_o` and is dropped. A header with bit 56 clear that arrives when no request is open also pulses `err_o` and is dropped.
- R6: A header that arrives while buffers of the previous header are still pending pulses `err_o`. It is dropped, and the pending count is unchanged.
- R7: A mega source descriptor (type 6) or mega destination descriptor (type 7) is emitted like type 2 or type 3. Its byte length is the 16-bit field times 16.
- R8: Type codes 4 and 8 to 15 pulse `err_o`, are dropped, and do not count as buffers.
- R9: `req_end_o` pulses together with the last buffer entry of a header whose bit 57 (end) is set. If such a header also declares zero buffers, `req_end_o` pulses together with that header. Headers with bit 57 clear never end the request, so a request can span a first, middle and last header.
- R10: At most one of `buf_valid_o`, `redirect_valid_o` and `err_o` is high in any cycle. All outputs are low during reset. `desc_ready_o` is high from the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_data_i | input | 64 | Descriptor word |
| desc_ready_o | output | 1 | Parser can accept a descriptor |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_addr_o | output | 44 | Redirect target address |
| buf_valid_o | output | 1 | Buffer entry pulse |
| buf_is_dst_o | output | 1 | Buffer entry is a destination |
| buf_addr_o | output | 44 | Buffer address |
| buf_len_o | output | 20 | Buffer length in bytes |
| req_start_o | output | 1 | Request start marker |
| req_end_o | output | 1 | Request end marker |
| req_id_o | output | 16 | Opaque request id for the markers |
| err_o | output | 1 | Framing or type error pulse |

## Verification
The assertions check, on every cycle, the invariants that do not depend on the stimulus. The three event kinds never overlap. Each buffer entry lowers the pending count by exactly one. An error never changes the pending count. An end marker always leaves the request closed. Ready stays high once asserted. The end-to-end behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These scenarios cover multi-header requests, next-table and null descriptors inside a packet, the ×16 expansion of mega lengths, the full count of 31, and the recovery after each kind of framing error.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int ADDR_W = 44;
  localparam int DLEN_W = 16;
  localparam int CNT_W  = 5;
  localparam int ID_W   = 16;
  localparam int LEN_W  = DLEN_W + 4;

  typedef enum logic [3:0] {
    T_NULL = 4'd0,
    T_HDR  = 4'd1,
    T_SRC  = 4'd2,
    T_DST  = 4'd3,
    T_NEXT = 4'd5,
    T_MSRC = 4'd6,
    T_MDST = 4'd7
  } dtype_e;

  typedef struct packed {
    logic              is_hdr;
    logic              is_buf;
    logic              is_next;
    logic              is_bad;
    logic              is_dst;
    logic              is_mega;
    logic              hs;
    logic              he;
    logic [CNT_W-1:0]  cnt;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [DLEN_W-1:0] dlen;
  } dfields_t;
endpackage

// File: rtl/dp_classify.sv
module dp_classify
  import dp_pkg::*;
(
  input  logic [63:0] desc_i,
  output dfields_t    f_o
);
  logic [3:0] t;
  assign t = desc_i[63:60];

  always_comb begin
    f_o         = '0;
    f_o.hs      = desc_i[56];
    f_o.he      = desc_i[57];
    f_o.cnt     = desc_i[40:36];
    f_o.id      = desc_i[15:0];
    f_o.addr    = desc_i[ADDR_W-1:0];
    f_o.dlen    = desc_i[59:44];
    f_o.is_dst  = (t == T_DST) || (t == T_MDST);
    f_o.is_mega = (t == T_MSRC) || (t == T_MDST);
    case (t)
      T_NULL: ;
      T_HDR:  f_o.is_hdr = 1'b1;
      T_NEXT: f_o.is_next = 1'b1;
      T_SRC, T_DST, T_MSRC, T_MDST: f_o.is_buf = 1'b1;
      default: f_o.is_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dp_frame.sv
module dp_frame
  import dp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  dfields_t          f_i,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              buf_valid_o,
  output logic              buf_is_dst_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              req_start_o,
  output logic              req_end_o,
  output logic [ID_W-1:0]   req_id_o,
  output logic              err_o
);
  logic [CNT_W-1:0] rem_q;
  logic             open_q, last_q;
  logic [LEN_W-1:0] len_d;

  assign len_d = f_i.is_mega ? {f_i.dlen, 4'b0} : {4'b0, f_i.dlen};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q            <= '0;
      open_q           <= 1'b0;
      last_q           <= 1'b0;
      redirect_valid_o <= 1'b0;
      redirect_addr_o  <= '0;
      buf_valid_o      <= 1'b0;
      buf_is_dst_o     <= 1'b0;
      buf_addr_o       <= '0;
      buf_len_o        <= '0;
      req_start_o      <= 1'b0;
      req_end_o        <= 1'b0;
      req_id_o         <= '0;
      err_o            <= 1'b0;
    end else begin
      redirect_valid_o <= 1'b0;
      buf_valid_o      <= 1'b0;
      req_start_o      <= 1'b0;
      req_end_o        <= 1'b0;
      err_o            <= 1'b0;
      if (acc_i) begin
        if (f_i.is_next) begin
          redirect_valid_o <= 1'b1;
          redirect_addr_o  <= f_i.addr;
        end else if (f_i.is_hdr) begin
          if (rem_q != '0 || (!f_i.hs && !open_q)) begin
            err_o <= 1'b1;
          end else begin
            rem_q       <= f_i.cnt;
            last_q      <= f_i.he;
            req_id_o    <= f_i.id;
            req_start_o <= f_i.hs;
            if (f_i.cnt == '0 && f_i.he) begin
              req_end_o <= 1'b1;
              open_q    <= 1'b0;
            end else begin
              open_q    <= 1'b1;
            end
          end
        end else if (f_i.is_buf) begin
          if (rem_q == '0) begin
            err_o <= 1'b1;
          end else begin
            buf_valid_o  <= 1'b1;
            buf_is_dst_o <= f_i.is_dst;
            buf_addr_o   <= f_i.addr;
            buf_len_o    <= len_d;
            rem_q        <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1) && last_q) begin
              req_end_o <= 1'b1;
              open_q    <= 1'b0;
            end
          end
        end else if (f_i.is_bad) begin
          err_o <= 1'b1;
        end
      end
    end
  end

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_valid_o, redirect_valid_o, err_o}));
  // R1
  buf_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o |-> (rem_q == $past(rem_q) - 1'b1));
  // R6
  err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(rem_q));
  // R9
  end_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_end_o |-> (!open_q && rem_q == '0));
endmodule

// File: rtl/desc_parser.sv
module desc_parser
  import dp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  input  logic [63:0]       desc_data_i,
  output logic              desc_ready_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              buf_valid_o,
  output logic              buf_is_dst_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              req_start_o,
  output logic              req_end_o,
  output logic [ID_W-1:0]   req_id_o,
  output logic              err_o
);
  dfields_t fields;
  logic     ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end
  assign desc_ready_o = ready_q;

  dp_classify i_classify (
    .desc_i (desc_data_i),
    .f_o    (fields)
  );

  dp_frame i_frame (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .acc_i            (desc_valid_i && ready_q),
    .f_i              (fields),
    .redirect_valid_o (redirect_valid_o),
    .redirect_addr_o  (redirect_addr_o),
    .buf_valid_o      (buf_valid_o),
    .buf_is_dst_o     (buf_is_dst_o),
    .buf_addr_o       (buf_addr_o),
    .buf_len_o        (buf_len_o),
    .req_start_o      (req_start_o),
    .req_end_o        (req_end_o),
    .req_id_o         (req_id_o),
    .err_o            (err_o)
  );

  // R10
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |=> desc_ready_o);
endmodule

// File: tb/test_desc_parser.sv
module test_desc_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic [63:0] desc_data = '0;
  logic        ready, rv, bv, bdst, rs, re, er;
  logic [43:0] ra, ba;
  logic [19:0] bl;
  logic [15:0] rid;

  always #4 clk = ~clk;

  desc_parser i_desc_parser (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(desc_valid), .desc_data_i(desc_data),
    .desc_ready_o(ready), .redirect_valid_o(rv), .redirect_addr_o(ra),
    .buf_valid_o(bv), .buf_is_dst_o(bdst), .buf_addr_o(ba), .buf_len_o(bl),
    .req_start_o(rs), .req_end_o(re), .req_id_o(rid), .err_o(er)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_rem = 0;
  bit m_open = 0, m_last = 0;
  logic [15:0] m_id = '0;
  bit e_rv, e_bv, e_dst, e_rs, e_re, e_er;
  logic [43:0] e_ra, e_ba;
  logic [19:0] e_bl;
  string tag = "R10";

  function automatic logic [63:0] mk_hdr(bit s, bit e, int c, logic [15:0] id);
    logic [4:0] c5 = c[4:0];
    return {4'd1, 2'b00, e, s, 15'h0, c5, 4'h0, 16'h0, id};
  endfunction
  function automatic logic [63:0] mk_buf(logic [3:0] t, logic [15:0] l, logic [43:0] a);
    return {t, l, a};
  endfunction

  task automatic model(bit v, logic [63:0] d);
    logic [3:0] t = d[63:60];
    {e_rv, e_bv, e_rs, e_re, e_er} = '0;
    tag = "R10";
    if (!v) return;
    case (t)
      4'd0: tag = "R3";
      4'd5: begin tag = "R2"; e_rv = 1; e_ra = d[43:0]; end
      4'd1: begin
        if (m_rem != 0) begin tag = "R6"; e_er = 1; end
        else if (!d[56] && !m_open) begin tag = "R5"; e_er = 1; end
        else begin
          tag = "R4";
          m_rem = int'(d[40:36]); m_last = d[57]; m_id = d[15:0];
          e_rs = d[56]; m_open = 1;
          if (m_rem == 0 && m_last) begin tag = "R9"; e_re = 1; m_open = 0; end
        end
      end
      4'd2, 4'd3, 4'd6, 4'd7: begin
        if (m_rem == 0) begin tag = "R5"; e_er = 1; end
        else begin
          tag = t[2] ? "R7" : "R1";
          e_bv = 1; e_dst = t[0]; e_ba = d[43:0];
          e_bl = t[2] ? 20'(d[59:44]) * 20'd16 : 20'(d[59:44]);
          m_rem--;
          if (m_rem == 0 && m_last) begin tag = "R9"; e_re = 1; m_open = 0; end
        end
      end
      default: begin tag = "R8"; e_er = 1; end
    endcase
  endtask

  task automatic compare();
    bit bad = 0;
    n_chk++;
    if (ready !== 1'b1 || rv !== e_rv || bv !== e_bv || rs !== e_rs || re !== e_re || er !== e_er) bad = 1;
    if (e_rv && ra !== e_ra) bad = 1;
    if (e_bv && (ba !== e_ba || bl !== e_bl || bdst !== e_dst)) bad = 1;
    if ((e_rs || e_re) && rid !== m_id) bad = 1;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got rdy=%b rv=%b ra=%h bv=%b dst=%b ba=%h bl=%h rs=%b re=%b id=%h er=%b exp rv=%b ra=%h bv=%b dst=%b ba=%h bl=%h rs=%b re=%b id=%h er=%b",
               tag, ready, rv, ra, bv, bdst, ba, bl, rs, re, rid, er,
               e_rv, e_ra, e_bv, e_dst, e_ba, e_bl, e_rs, e_re, m_id, e_er);
    end
  endtask

  task automatic step(bit v, logic [63:0] d);
    desc_valid = v; desc_data = d;
    @(posedge clk);
    model(v, d);
    @(negedge clk);
    compare();
    desc_valid = 0;
  endtask

  task automatic send(logic [63:0] d);
    step(1'b1, d);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R10: watchdog expired got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if ({ready, rv, bv, rs, re, er} !== 6'b0) begin
      n_fail++;
      $display("FAIL R10: reset outputs got %b expected 000000", {ready, rv, bv, rs, re, er});
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, '0);
    // R1 R4 R9: single-header request
    send(mk_hdr(1, 1, 2, 16'h1234));
    send(mk_buf(4'd2, 16'h0040, 44'h123_4567_89AB));
    send(mk_buf(4'd3, 16'h0013, 44'hFFF_FFFF_FFFF));
    step(0, '0);
    // R2 R3 R7: chaining and null inside a packet
    send(mk_hdr(1, 1, 3, 16'hBEEF));
    send(mk_buf(4'd2, 16'h0001, 44'h10));
    send({4'd5, 16'hFFFF, 44'hABC_DEF0_1230});
    send({4'd0, 60'h0FF_FFFF_FFFF_FFFF});
    send(mk_buf(4'd6, 16'hFFFF, 44'h200));
    send(mk_buf(4'd7, 16'h0003, 44'h300));
    // R9: multi-header request
    send(mk_hdr(1, 0, 1, 16'h0A0A));
    send(mk_buf(4'd2, 16'h0100, 44'h1000));
    send(mk_hdr(0, 0, 1, 16'h0A0A));
    send({4'd5, 16'h0, 44'h8000});
    send(mk_buf(4'd3, 16'h0200, 44'h2000));
    send(mk_hdr(0, 1, 1, 16'h0A0A));
    send(mk_buf(4'd7, 16'h0010, 44'h3000));
    // R4 R9: zero-count header
    send(mk_hdr(1, 1, 0, 16'h5555));
    // R5: framing errors
    send(mk_buf(4'd2, 16'h0008, 44'h40));
    send(mk_hdr(0, 1, 1, 16'h7777));
    send(mk_buf(4'd3, 16'h0008, 44'h40));
    // R6 R8: errors inside a packet, then recovery
    send(mk_hdr(1, 1, 2, 16'h9999));
    send(mk_hdr(1, 1, 5, 16'h1111));
    send(mk_buf(4'd2, 16'h0004, 44'h50));
    send({4'd4, 60'h1});
    send({4'd9, 60'h2});
    send({4'd15, 60'h3});
    send(mk_buf(4'd3, 16'h0004, 44'h60));
    step(0, '0);
    // R4 R9: maximum buffer count
    send(mk_hdr(1, 1, 31, 16'hC0DE));
    for (int i = 0; i < 31; i++) begin
      logic [3:0] ty = (i % 2 == 0) ? 4'd2 : 4'd6;
      send(mk_buf(ty, 16'(i + 1), 44'(i * 64)));
    end
    send(mk_buf(4'd2, 16'h1, 44'h1));
    // R9: end=0 header never ends the request
    send(mk_hdr(1, 0, 1, 16'h2222));
    send(mk_buf(4'd2, 16'h2, 44'h2));
    send(mk_hdr(0, 1, 0, 16'h2222));
    repeat (2) step(0, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule